// File: doc/BRIEF.md
# Integer ALU with Mirrored Carry Status

This block is the integer execution datapath of a small scalar core. Each cycle it takes two 32-bit operands and an operation code. It returns a result word with no register in the path. It also keeps a status word in which the carry flag is held in two bit positions at once. Operand B may already carry a sign-extended immediate, so register and immediate forms share one path.

Subtraction is reversed: the block computes B minus A as B + ~A + carry-in. Each add or subtract comes in four flavours: plain, reverse, with stored carry, and reverse with stored carry. A keep input stops any of them from changing the stored carry. The compares return the B-minus-A difference with its top bit corrected, so the sign of the word gives the order of the operands.

The single-bit right shifts always pass operand bit 0 into the carry. The other operations are the four bitwise operations and byte and halfword sign extension. An issue strobe marks the cycles in which an operation actually retires and may update the status word.

Top module: `alu_carry_core`

## Requirements
- R1: Operation codes are given on `op_sel`. Code 0 gives A+B and code 2 gives A+B+C, where C is the stored carry at status bit 2.
- R2: Code 1 gives B+~A+1 and code 3 gives B+~A+C.
- R3: For codes 0 to 3, the carry out is bit 32 of the 33-bit unsigned sum of the two addends plus the carry-in. When `issue`=1 and `keep_carry`=0, this carry is written on the next clock edge to status bits 2 and 31 together.
- R4: When `keep_carry`=1, codes 0 to 3 produce the same result and the status word does not change.
- R5: Code 4 (signed compare) returns B+~A+1. When A[31] and B[31] differ, bit 31 of that value is replaced by B[31]. The status word does not change.
- R6: Code 5 (unsigned compare) returns the same difference. When the sign bits differ, bit 31 is replaced by A[31]. The status word does not change.
- R7: Codes 6, 7, 8 and 9 return A|B, A&B, A^B and A&~B. The status word does not change.
- R8: Codes 10, 11 and 12 shift A right by one bit. Code 10 fills bit 31 with A[31], code 11 fills it with the stored carry, and code 12 fills it with 0. When `issue`=1, A[0] becomes the new carry regardless of `keep_carry`.
- R9: Codes 13 and 14 replicate A[7] or A[15] into all higher bits. The status word does not change.
- R10: Reset clears the whole status word. Status bits other than 2 and 31 never change. When `issue`=0, nothing in the status word changes.
- R11: `carry_next` equals the carry that the status word will hold after the current clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status word |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation retires this cycle |
| op_sel | input | 4 | Operation code |
| keep_carry | input | 1 | Suppress carry write for add/subtract |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B or extended immediate |
| result | output | 32 | Combinational result |
| status | output | 32 | Status word, carry at bits 2 and 31 |
| carry_next | output | 1 | Carry after the coming edge |

## Verification
In one cycle, an add-with-carry, reverse-subtract-with-carry or shift-through-carry both reads the stored carry and replaces it with its own carry out. The bench exercises this by running every operation code back to back over a grid of corner operands. That grid includes all-ones, zero and sign-boundary words, so each carry-consuming operation sees the carry left by the one before it. Each result is compared with a carry model held in the bench, and the status word is checked after each edge to confirm that the old carry was consumed and the new one stored, both in the same cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_RSUB  = 4'd1,
    OP_ADDC  = 4'd2,
    OP_RSUBC = 4'd3,
    OP_CMP   = 4'd4,
    OP_CMPU  = 4'd5,
    OP_OR    = 4'd6,
    OP_AND   = 4'd7,
    OP_XOR   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_SRA   = 4'd10,
    OP_SRC   = 4'd11,
    OP_SRL   = 4'd12,
    OP_SEXT8 = 4'd13,
    OP_SEXT16= 4'd14,
    OP_NONE  = 4'd15
  } alu_op_e;

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_RSUB) || (op == OP_ADDC) || (op == OP_RSUBC);
  endfunction

  function automatic logic is_shift(alu_op_e op);
    return (op == OP_SRA) || (op == OP_SRC) || (op == OP_SRL);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              invert_a,
  input  logic              swap,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] x_op;
  logic [DATA_W-1:0] y_op;
  logic [EXT_W-1:0]  wide;

  always_comb begin
    x_op = swap ? b_in : a_in;
    y_op = swap ? (invert_a ? ~a_in : a_in) : b_in;
    wide = {1'b0, x_op} + {1'b0, y_op} + {{DATA_W{1'b0}}, cin};
    sum  = wide[DATA_W-1:0];
    cout = wide[DATA_W];
  end

  always_comb begin
    if (!$isunknown({x_op, y_op, cin}))
      AST_ALL_ONES_CARRY: assert (!((y_op == {DATA_W{1'b1}}) && cin) || cout); // R3
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DATA_W = 32
) (
  input  alu_pkg::alu_op_e  op,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] res
);
  import alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_OR:   res = a_in | b_in;
      OP_AND:  res = a_in & b_in;
      OP_XOR:  res = a_in ^ b_in;
      OP_ANDN: res = a_in & ~b_in;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_shext.sv
module alu_shext #(
  parameter int DATA_W = 32
) (
  input  alu_pkg::alu_op_e  op,
  input  logic [DATA_W-1:0] a_in,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  import alu_pkg::*;
  localparam int MSB = DATA_W - 1;

  logic fill;

  always_comb begin
    unique case (op)
      OP_SRA:  fill = a_in[MSB];
      OP_SRC:  fill = cin;
      default: fill = 1'b0;
    endcase
    cout = a_in[0];
    unique case (op)
      OP_SRA, OP_SRC, OP_SRL: res = {fill, a_in[MSB:1]};
      OP_SEXT8:  res = {{(DATA_W-BYTE_W){a_in[BYTE_W-1]}}, a_in[BYTE_W-1:0]};
      OP_SEXT16: res = {{(DATA_W-HALF_W){a_in[HALF_W-1]}}, a_in[HALF_W-1:0]};
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int STAT_W = 32,
  parameter int C_LO   = 2,
  parameter int C_HI   = STAT_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_val,
  output logic [STAT_W-1:0] stat_q,
  output logic              carry_q
);
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en) begin
      stat_d[C_LO] = wr_val;
      stat_d[C_HI] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= '0;
    else if (wr_en) stat_q <= stat_d;
  end

  assign carry_q = stat_q[C_LO];

  AST_CARRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stat_q[C_LO] == $past(wr_val)) && (stat_q[C_HI] == $past(wr_val))); // R3
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stat_q)); // R10
endmodule

// File: rtl/alu_carry_core.sv
module alu_carry_core #(
  parameter int DATA_W = 32,
  parameter int CARRY_LO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [3:0]        op_sel,
  input  logic              keep_carry,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] status,
  output logic              carry_next
);
  import alu_pkg::*;
  localparam int MSB = DATA_W - 1;

  alu_op_e op;
  logic    carry_q;
  logic    as_invert, as_swap, as_cin, as_cout;
  logic [DATA_W-1:0] as_sum, bw_res, sx_res, cmp_res;
  logic    sx_cout;
  logic    carry_wr;
  logic    carry_val;

  assign op = alu_op_e'(op_sel);

  // adder control: reverse forms swap B into the first addend and invert A
  always_comb begin
    as_swap   = 1'b1;
    as_invert = 1'b1;
    as_cin    = 1'b1;
    unique case (op)
      OP_ADD:   begin as_swap = 1'b0; as_invert = 1'b0; as_cin = 1'b0;    end
      OP_ADDC:  begin as_swap = 1'b0; as_invert = 1'b0; as_cin = carry_q; end
      OP_RSUBC: begin as_cin = carry_q; end
      default:  ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_in(op_a), .b_in(op_b), .invert_a(as_invert), .swap(as_swap),
    .cin(as_cin), .sum(as_sum), .cout(as_cout)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .op(op), .a_in(op_a), .b_in(op_b), .res(bw_res)
  );

  alu_shext #(.DATA_W(DATA_W)) u_shext (
    .op(op), .a_in(op_a), .cin(carry_q), .res(sx_res), .cout(sx_cout)
  );

  // compare: difference with the top bit repaired on sign mismatch
  always_comb begin
    cmp_res = as_sum;
    if (op_a[MSB] != op_b[MSB])
      cmp_res[MSB] = (op == OP_CMPU) ? op_a[MSB] : op_b[MSB];
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_RSUB, OP_ADDC, OP_RSUBC: result = as_sum;
      OP_CMP, OP_CMPU:                    result = cmp_res;
      OP_OR, OP_AND, OP_XOR, OP_ANDN:     result = bw_res;
      OP_SRA, OP_SRC, OP_SRL,
      OP_SEXT8, OP_SEXT16:                result = sx_res;
      default:                            result = '0;
    endcase
  end

  always_comb begin
    carry_wr  = issue && ((is_arith(op) && !keep_carry) || is_shift(op));
    carry_val = is_shift(op) ? sx_cout : as_cout;
    carry_next = carry_wr ? carry_val : carry_q;
  end

  alu_status #(.STAT_W(DATA_W), .C_LO(CARRY_LO_BIT), .C_HI(MSB)) u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(carry_wr), .wr_val(carry_val),
    .stat_q(status), .carry_q(carry_q)
  );

  AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && keep_carry && is_arith(op)) |=> $stable(status)); // R4
  AST_CMP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP || op == OP_CMPU) |=> $stable(status)); // R5
  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_shift(op)) |=> status[CARRY_LO_BIT] == $past(op_a[0])); // R8
  AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status[CARRY_LO_BIT] == $past(carry_next)); // R11
  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status[CARRY_LO_BIT] == status[MSB]); // R10
endmodule

// File: tb/sim_alu_carry_core.sv
module sim_alu_carry_core;
  logic        clk;
  logic        rst_n;
  logic        issue;
  logic [3:0]  op_sel;
  logic        keep_carry;
  logic [31:0] op_a, op_b;
  logic [31:0] result, status;
  logic        carry_next;

  int checks = 0;
  int fails  = 0;
  logic mc;
  bit done = 0;

  alu_carry_core u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_sel(op_sel),
    .keep_carry(keep_carry), .op_a(op_a), .op_b(op_b),
    .result(result), .status(status), .carry_next(carry_next)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op <= 1)  return "R1_R2";
    if (op <= 3)  return "R1_R2_R3";
    if (op == 4)  return "R5";
    if (op == 5)  return "R6";
    if (op <= 9)  return "R7";
    if (op <= 12) return "R8";
    return "R9";
  endfunction

  task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic kp, input logic iss);
    logic [32:0] w;
    logic [31:0] er;
    logic ec;
    logic wr;
    @(negedge clk);
    op_sel = op[3:0]; op_a = a; op_b = b; keep_carry = kp; issue = iss;
    #1;
    w = '0; er = '0; ec = 1'b0; wr = 1'b0;
    case (op)
      0: w = {1'b0, a} + {1'b0, b};
      1: w = {1'b0, b} + {1'b0, ~a} + 33'd1;
      2: w = {1'b0, a} + {1'b0, b} + {32'd0, mc};
      3: w = {1'b0, b} + {1'b0, ~a} + {32'd0, mc};
      4, 5: begin
        er = b - a;
        if (a[31] != b[31]) er[31] = (op == 4) ? b[31] : a[31];
      end
      6: er = a | b;
      7: er = a & b;
      8: er = a ^ b;
      9: er = a & ~b;
      10: begin er = {a[31], a[31:1]}; ec = a[0]; wr = 1'b1; end
      11: begin er = {mc, a[31:1]};    ec = a[0]; wr = 1'b1; end
      12: begin er = {1'b0, a[31:1]};  ec = a[0]; wr = 1'b1; end
      13: er = {{24{a[7]}}, a[7:0]};
      14: er = {{16{a[15]}}, a[15:0]};
      default: er = '0;
    endcase
    if (op <= 3) begin er = w[31:0]; ec = w[32]; wr = !kp; end
    wr = wr && iss;
    chk(req_of(op), result, er);
    if (wr) mc = ec;
    chk("R11", {31'd0, carry_next}, {31'd0, mc});
    @(posedge clk);
    #1;
    chk((op <= 3 && kp) ? "R4" : (!iss ? "R10" : "R3_R10"), status, {mc, 28'd0, mc, 2'b00});
  endtask

  initial begin
    logic [31:0] vals [12];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFE,
             32'h0000_0080, 32'h0000_8000, 32'h0000_7F7F, 32'h1234_5678, 32'h8765_4321,
             32'h5555_AAAA};
    rst_n = 1'b0; issue = 1'b0; op_sel = '0; keep_carry = 1'b0; op_a = '0; op_b = '0;
    mc = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", status, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R3: all-ones second addend with carry-in set must produce carry
    run_op(12, 32'h1, 32'h0, 1'b0, 1'b1);   // set carry from A[0]
    run_op(3, 32'h0, 32'h0, 1'b0, 1'b1);    // B + ~0 + 1 -> carry out
    // R10: issue low leaves status alone even for a shift
    run_op(12, 32'h0, 32'h0, 1'b0, 1'b0);
    for (int k = 0; k < 2; k++)
      for (int op = 0; op < 15; op++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            run_op(op, vals[i], vals[j], k[0], 1'b1);
    // R4: keep set across a carry-producing subtract chain
    run_op(1, 32'h0, 32'h5, 1'b1, 1'b1);
    run_op(0, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule